// File: doc/BRIEF.md
# Random Number Generator Register Unit

This block is the software-facing front end of a hardware random number generator. A plain strobe bus reads and writes six 32-bit word registers: an identity word, a command word, a control word, a status word, an error word and a data port that pops the output queue. Software starts a self-test or a seed operation through the command word. It waits for the matching done flag or the interrupt, then drains random words through the data port while the status word reports how many are queued.

The entropy source is replaced by a deterministic stand-in. Every operation takes `OP_LATENCY` cycles. The input `stat_err_inject` makes a seed operation end with a statistical-test failure. After a clean seed, a 32-bit shift-register generator fills the queue at one word per cycle. It pauses while an operation runs or an error is held. A served-word counter restarts seeding on its own after `RESEED_WORDS` words when auto-seeding is on. The default is 2^20.

Top module: `rng_regfile`

## Requirements
- R1: The word at byte offset 0x00 reads as the variant code in bits 31:28 (1 = B, 2 = C), the major revision in bits 15:8 and the minor revision in bits 7:0. The defaults are variant 2, major 1 and minor 3, giving 0x20000103.
- R2: After reset, the control word at 0x08 reads 0x60: the done mask (bit 5) and the error mask (bit 6) are set and auto-seed (bit 4) is clear. The status word at 0x0C reads 0 and `irq` is low.
- R3: A write to the command word at 0x04 with bit 0 starts a self-test and with bit 1 starts a seed. If both bits are set, the self-test wins. The status done bit (bit 4 for self-test, bit 5 for seed) rises exactly `OP_LATENCY` cycles after the write edge. A start command written while an operation runs is ignored. The command word always reads 0.
- R4: A seed that ends with `stat_err_inject` high sets error-word (0x10) bit 3 and status bit 16, in addition to the seed done bit.
- R5: `irq` is high exactly when (a done bit is set and the done mask is clear) or (an error is held and the error mask is clear).
- R6: Command bit 4 clears both done bits only when no error is held; with an error held it changes nothing.
- R7: Command bit 5 clears both done bits and the whole error word.
- R8: The status field in bits 11:8 gives the queue level. After a clean seed the queue fills to `FIFO_DEPTH`. No words are added while an operation runs. Each read of the data port at 0x14 with a non-zero level lowers the level by one.
- R9: A read of the data port while the level is 0 returns 0 and leaves the level at 0.
- R10: With auto-seed on, the read that serves the `RESEED_WORDS`-th word since the last seed start launches a new seed on the next cycle. With auto-seed off, no seed starts however many words are read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; pops the queue at 0x14 |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Level interrupt |
| stat_err_inject | input | 1 | Stand-in failure flag sampled when a seed ends |

## Verification
The bench issues a second start command in the middle of a running seed. A design that accepted it would restart the timer or flag a self-test done. It checks the clear-interrupt command while an error is held, because a design that clears symmetrically would drop the interrupt and the seed done bit early. It drains words during an operation to pin down the level arithmetic, and it reads the empty queue to catch an underflowing level or stale data. It also counts served words on both sides of the reseed threshold, with auto-seed on and off, to expose an off-by-one trigger or a trigger that ignores the enable.

// File: rtl/rng_regfile.sv
module rng_regfile #(
  parameter int ADDR_W       = 5,
  parameter int FIFO_DEPTH   = 8,
  parameter int OP_LATENCY   = 64,
  parameter int RESEED_WORDS = 1 << 20,
  parameter int VARIANT      = 2,
  parameter int REV_MAJOR    = 1,
  parameter int REV_MINOR    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  input  logic              stat_err_inject
);
  localparam int IW = ADDR_W - 2;
  localparam int PW = $clog2(FIFO_DEPTH);
  localparam int LW = PW + 1;
  localparam int TW = $clog2(OP_LATENCY + 1);
  localparam int CW = $clog2(RESEED_WORDS + 1);

  logic [IW-1:0] idx;
  assign idx = bus_addr[ADDR_W-1:2];

  logic wr_cmd, wr_ctrl, rd_data;
  assign wr_cmd  = bus_wr && idx == IW'(1);
  assign wr_ctrl = bus_wr && idx == IW'(2);
  assign rd_data = bus_rd && idx == IW'(5);

  logic auto_q, mdone_q, merr_q;
  logic busy_q, op_seed_q, seeded_q;
  logic [TW-1:0] timer_q;
  logic st_done_q, seed_done_q, stat_err_q;
  logic [CW-1:0] served_q;
  logic [LW-1:0] level_q;
  logic [PW-1:0] wptr_q, rptr_q;
  logic [31:0] lfsr_q;
  logic [31:0] mem [FIFO_DEPTH];

  logic finish, start_st, start_man, auto_go, start_seed, clr_int, clr_err;
  logic push, pop;

  assign finish     = busy_q && timer_q == TW'(1);
  assign start_st   = wr_cmd && bus_wdata[0] && !busy_q;
  assign start_man  = wr_cmd && bus_wdata[1] && !bus_wdata[0] && !busy_q;
  assign auto_go    = auto_q && !busy_q && !start_st && !start_man &&
                      served_q == CW'(RESEED_WORDS);
  assign start_seed = start_man || auto_go;
  assign clr_int    = wr_cmd && bus_wdata[4];
  assign clr_err    = wr_cmd && bus_wdata[5];

  assign pop  = rd_data && level_q != '0;
  assign push = seeded_q && !busy_q && !stat_err_q &&
                (level_q < LW'(FIFO_DEPTH) || pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_q  <= 1'b0;
      mdone_q <= 1'b1;
      merr_q  <= 1'b1;
    end else if (wr_ctrl) begin
      auto_q  <= bus_wdata[4];
      mdone_q <= bus_wdata[5];
      merr_q  <= bus_wdata[6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      op_seed_q <= 1'b0;
      timer_q   <= '0;
    end else if (start_st || start_seed) begin
      busy_q    <= 1'b1;
      op_seed_q <= start_seed;
      timer_q   <= TW'(OP_LATENCY);
    end else if (finish) begin
      busy_q  <= 1'b0;
      timer_q <= '0;
    end else if (busy_q) begin
      timer_q <= timer_q - TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_done_q   <= 1'b0;
      seed_done_q <= 1'b0;
      stat_err_q  <= 1'b0;
      seeded_q    <= 1'b0;
    end else begin
      if (clr_err || (clr_int && !stat_err_q)) begin
        st_done_q   <= 1'b0;
        seed_done_q <= 1'b0;
      end
      if (clr_err) stat_err_q <= 1'b0;
      if (finish) begin
        if (op_seed_q) begin
          seed_done_q <= 1'b1;
          if (stat_err_inject) stat_err_q <= 1'b1;
          else                 seeded_q   <= 1'b1;
        end else begin
          st_done_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  served_q <= '0;
    else if (start_seed)                         served_q <= '0;
    else if (pop && served_q != CW'(RESEED_WORDS)) served_q <= served_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      wptr_q  <= '0;
      rptr_q  <= '0;
      lfsr_q  <= 32'hACE1_2468;
    end else begin
      if (push) begin
        wptr_q <= wptr_q + PW'(1);
        lfsr_q <= {lfsr_q[30:0], lfsr_q[31] ^ lfsr_q[21] ^ lfsr_q[1] ^ lfsr_q[0]};
      end
      if (pop) rptr_q <= rptr_q + PW'(1);
      level_q <= level_q + LW'(push) - LW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= lfsr_q;
  end

  always_comb begin
    case (idx)
      IW'(0):  bus_rdata = {4'(VARIANT), 12'b0, 8'(REV_MAJOR), 8'(REV_MINOR)};
      IW'(2):  bus_rdata = {25'b0, merr_q, mdone_q, auto_q, 4'b0};
      IW'(3):  bus_rdata = {15'b0, stat_err_q, 4'b0, 4'(level_q), 2'b0,
                            seed_done_q, st_done_q, 4'b0};
      IW'(4):  bus_rdata = {28'b0, stat_err_q, 3'b0};
      IW'(5):  bus_rdata = (level_q != '0) ? mem[rptr_q] : 32'b0;
      default: bus_rdata = 32'b0;
    endcase
  end

  assign irq = ((st_done_q || seed_done_q) && !mdone_q) || (stat_err_q && !merr_q);

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[31:7], bus_wdata[3:2], bus_addr[1:0]};
endmodule

// File: rtl/rng_regfile_sva.sv
module rng_regfile_sva #(
  parameter int ADDR_W     = 5,
  parameter int FIFO_DEPTH = 8,
  parameter int TW         = 4,
  parameter int LW         = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              irq,
  input logic              busy_q,
  input logic [TW-1:0]     timer_q,
  input logic [LW-1:0]     level_q,
  input logic              st_done_q,
  input logic              seed_done_q,
  input logic              stat_err_q,
  input logic              mdone_q,
  input logic              merr_q,
  input logic              finish
);
  localparam int IW = ADDR_W - 2;
  logic [IW-1:0] idx;
  assign idx = bus_addr[ADDR_W-1:2];

  p_level_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LW'(FIFO_DEPTH));

  p_level_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (level_q == $past(level_q)) || (level_q == $past(level_q) + LW'(1)) ||
             (level_q + LW'(1) == $past(level_q)));

  p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && idx == IW'(5) && level_q == '0) |-> bus_rdata == 32'b0);

  p_cmd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && idx == IW'(1)) |-> bus_rdata == 32'b0);

  p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && timer_q != TW'(1)) |=> busy_q && timer_q == $past(timer_q) - TW'(1));

  p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mdone_q && merr_q) |-> !irq);

  p_clr_int_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && idx == IW'(1) && bus_wdata[4] && !bus_wdata[5] && stat_err_q && seed_done_q)
      |=> seed_done_q && stat_err_q);

  p_clr_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && idx == IW'(1) && bus_wdata[5] && !finish)
      |=> !stat_err_q && !st_done_q && !seed_done_q);

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[31:6], bus_wdata[3:0], bus_addr[1:0]};
endmodule

bind rng_regfile rng_regfile_sva #(
  .ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH), .TW(TW), .LW(LW)
) u_sva (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq(irq), .busy_q(busy_q), .timer_q(timer_q), .level_q(level_q),
  .st_done_q(st_done_q), .seed_done_q(seed_done_q), .stat_err_q(stat_err_q),
  .mdone_q(mdone_q), .merr_q(merr_q), .finish(finish)
);

// File: tb/rng_regfile_tb.sv
module rng_regfile_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT   = 8;
  localparam int DEPTH = 8;
  localparam int RSW   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, inj = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rng_regfile #(.OP_LATENCY(LAT), .FIFO_DEPTH(DEPTH), .RESEED_WORDS(RSW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .stat_err_inject(inj));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    bus_addr = 5'(idx << 2); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    bus_addr = 5'(idx << 2); bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(0, d); chk("R1 version", d, 32'h2000_0103);
    rd(2, d); chk("R2 control reset", d, 32'h60);
    rd(3, d); chk("R2 status reset", d, 32'h0);
    chk("R2 irq reset", 32'(irq), 0);
  endtask

  task automatic t_empty_read;
    logic [31:0] d;
    rd(5, d); chk("R9 empty read data", d, 0);
    rd(3, d); chk("R9 level stays 0", (d >> 8) & 32'hF, 0);
  endtask

  task automatic t_seed_timing;
    logic [31:0] d;
    wr(1, 32'h2);
    wr(1, 32'h1);
    idle(LAT - 3);
    rd(3, d); chk("R3 not done before latency", d & 32'h30, 0);
    idle(1);
    rd(3, d); chk("R3 seed done, busy start ignored", d & 32'h30, 32'h20);
    rd(1, d); chk("R3 command reads zero", d, 0);
    chk("R5 irq masked", 32'(irq), 0);
  endtask

  task automatic t_fill_drain;
    logic [31:0] d;
    idle(12);
    rd(3, d); chk("R8 fills to depth", (d >> 8) & 32'hF, DEPTH);
    wr(1, 32'h1);
    rd(5, d); rd(5, d); rd(5, d);
    rd(3, d); chk("R8 reads lower level during op", (d >> 8) & 32'hF, DEPTH - 3);
    idle(LAT);
    rd(3, d); chk("R3 self-test done", d & 32'h30, 32'h30);
  endtask

  task automatic t_irq_clear;
    logic [31:0] d;
    wr(2, 32'h40);
    chk("R5 irq on unmasked done", 32'(irq), 1);
    wr(1, 32'h10);
    chk("R6 irq cleared", 32'(irq), 0);
    rd(3, d); chk("R6 done bits cleared", d & 32'h30, 0);
  endtask

  task automatic t_auto_on;
    logic [31:0] d;
    wr(1, 32'h2);
    idle(LAT + 2);
    wr(1, 32'h10);
    wr(2, 32'h10);
    idle(4);
    rd(5, d); rd(5, d); rd(5, d);
    idle(LAT + 2);
    rd(3, d); chk("R10 no reseed below threshold", d & 32'h20, 0);
    rd(5, d);
    idle(LAT + 3);
    rd(3, d); chk("R10 auto reseed at threshold", d & 32'h20, 32'h20);
    chk("R5 irq on auto reseed done", 32'(irq), 1);
    wr(2, 32'h60);
    wr(1, 32'h10);
  endtask

  task automatic t_error;
    logic [31:0] d;
    inj = 1'b1;
    wr(1, 32'h2);
    idle(LAT + 2);
    inj = 1'b0;
    rd(3, d); chk("R4 status error and done", d & 32'h1_0030, 32'h1_0020);
    rd(4, d); chk("R4 error word", d, 32'h8);
    chk("R5 irq masked error", 32'(irq), 0);
    wr(2, 32'h20);
    chk("R5 irq on unmasked error", 32'(irq), 1);
    wr(1, 32'h10);
    chk("R6 irq held with error", 32'(irq), 1);
    rd(3, d); chk("R6 done held with error", d & 32'h1_0030, 32'h1_0020);
    wr(1, 32'h20);
    chk("R7 irq cleared", 32'(irq), 0);
    rd(4, d); chk("R7 error word cleared", d, 0);
    rd(3, d); chk("R7 status cleared", d & 32'h1_0030, 0);
    wr(2, 32'h60);
  endtask

  task automatic t_auto_off;
    logic [31:0] d;
    wr(1, 32'h2);
    idle(LAT + 2);
    wr(1, 32'h10);
    idle(4);
    for (int i = 0; i < RSW + 1; i++) rd(5, d);
    idle(LAT + 3);
    rd(3, d); chk("R10 no reseed when disabled", d & 32'h30, 0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_empty_read();
    t_seed_timing();
    t_fill_drain();
    t_irq_clear();
    t_auto_on();
    t_error();
    t_auto_off();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule